// File: doc/BRIEF.md
# Enabled BAR Address Window Decoder

This block decides which of three address windows an incoming physical address falls in and how far into that window it lands. Two of the windows are memory windows. Each has a programmable base and a programmable mask, and the window's span is taken from the inverted mask. The third window holds registers: it has a programmable base and a fixed span of 0x1000. A separate enable register switches each window on or off.

Software sets up the windows through a small register port that carries only 64-bit words. The register index is the byte address shifted right by three. Base and mask values sit in their registers shifted left by 14 bits, and the decoder shifts them back down to get effective addresses. Writes are filtered bit by bit when they are stored. Any write the block considers illegal sets a sticky error flag.

The lookup path is purely combinational from `lk_addr` to the hit, select and offset outputs. A configuration write takes effect on the clock edge that accepts it. There is no internal sequencing beyond the register bank: the only states are the stored configuration and the sticky error bit.

Top module: `bar_window_decoder`

## Requirements
- R1: The register index is `cfg_addr[5:3]`. Index 0 is the memory window 0 base, 1 the memory window 1 base, 2 the memory window 0 mask, 3 the memory window 1 mask, 4 the register-window base and 5 the enable register. A read (`cfg_rd`) places the stored value of the indexed register on `cfg_rdata` after the next rising edge. Indices 6 and 7 read as zero.
- R2: A write to either memory-window base or mask stores only bits 63..30 of the write data and clears the rest.
- R3: A write to the register-window base stores only bits 63..26.
- R4: A write to the enable register stores only bits 63..59. Bit 63 enables memory window 0, bit 62 enables memory window 1 and bit 61 enables the register window.
- R5: After reset the stored values are as follows. Memory window 0 base is 0x0000_4000_0000_0000 and its mask is 0xFFFF_FC00_0000_0000. Memory window 1 base is 0x0000_8000_0000_0000 and its mask is 0xFFFF_FFC0_0000_0000. The register-window base is 0x0000_C000_0000_0000. The enable register is zero, and `cfg_err` is low.
- R6: For a memory window, the effective base is the stored base shifted right by 14. The size is ((NOT mask) shifted right by 14) + 1. The window covers base ≤ `lk_addr` < base + size.
- R7: The register window covers its effective base (stored base shifted right by 14) up to but not including base + 0x1000.
- R8: A window reports a hit on `win_hit` (bit 0 memory window 0, bit 1 memory window 1, bit 2 register window) only while its enable bit is set.
- R9: `win_offset` equals `lk_addr` minus the base of the selected window, and is zero when no window is selected.
- R10: `win_sel` is one-hot with the same bit order as `win_hit`. Memory window 0 takes precedence over memory window 1, which takes precedence over the register window. `win_sel` is all zero when nothing hits.
- R11: Some writes are still stored but raise `cfg_err`. These are a write to any memory-window base or mask while either memory window is enabled, and a write to the register-window base while the register window is enabled. A write to the enable register never raises the flag.
- R12: Two kinds of write are not stored and raise `cfg_err`: a write to index 6 or 7, and a write whose `cfg_addr[2:0]` is nonzero.
- R13: `cfg_err` stays high until `err_clr` is asserted. If a new error and `err_clr` arrive in the same cycle, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 6 | Register byte address |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, valid the cycle after `cfg_rd` |
| err_clr | input | 1 | Clears the sticky error flag |
| cfg_err | output | 1 | Sticky illegal-update flag |
| lk_addr | input | 50 | Physical address to decode |
| win_hit | output | 3 | Raw per-window hit, gated by enables |
| win_sel | output | 3 | Priority-selected window, one-hot |
| win_offset | output | 50 | Offset of `lk_addr` within the selected window |

## Verification
Lookups are tried in several settings: with all windows disabled, with one window enabled, and with all three enabled at their disjoint defaults. In each case the first and last address inside a window are probed, along with the addresses just below and just past it, which separates an inclusive upper bound from an exclusive one and catches any error in how the size is derived. The windows are then moved so that all three overlap. Enables are removed one at a time so that each priority level shows up separately on `win_sel` while `win_hit` keeps reporting every raw hit. Configuration writes are issued with the gating enables both off and on, and to unknown and misaligned addresses, so that stored-versus-dropped and flagged-versus-silent can be told apart.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    localparam int REG_W    = 64;
    localparam int NUM_REGS = 6;
    localparam int NWIN     = 3;

    typedef enum logic [2:0] {
        IDX_MEM0_BASE = 3'd0,
        IDX_MEM1_BASE = 3'd1,
        IDX_MEM0_MASK = 3'd2,
        IDX_MEM1_MASK = 3'd3,
        IDX_REGW_BASE = 3'd4,
        IDX_WIN_EN    = 3'd5
    } cfg_idx_e;

    typedef enum int {
        WIN_MEM0 = 0,
        WIN_MEM1 = 1,
        WIN_REGW = 2
    } win_id_e;

    localparam int EN_MEM0_BIT = 63;
    localparam int EN_MEM1_BIT = 62;
    localparam int EN_REGW_BIT = 61;

    localparam logic [REG_W-1:0] MEM_KEEP  = 64'hFFFF_FFFF_C000_0000;
    localparam logic [REG_W-1:0] REGW_KEEP = 64'hFFFF_FFFF_FC00_0000;
    localparam logic [REG_W-1:0] EN_KEEP   = 64'hF800_0000_0000_0000;

endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
    import bar_dec_pkg::*;
#(
    parameter int               ADDR_W      = 6,
    parameter int               SHIFT       = 14,
    parameter logic [REG_W-1:0] DEF_M0_BASE = 64'h0000_4000_0000_0000,
    parameter logic [REG_W-1:0] DEF_M1_BASE = 64'h0000_8000_0000_0000,
    parameter logic [REG_W-1:0] DEF_M0_MASK = 64'hFFFF_FC00_0000_0000,
    parameter logic [REG_W-1:0] DEF_M1_MASK = 64'hFFFF_FFC0_0000_0000,
    parameter logic [REG_W-1:0] DEF_RW_BASE = 64'h0000_C000_0000_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic                   cfg_rd,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic [REG_W-1:0]       cfg_rdata,
    input  logic                   err_clr,
    output logic                   cfg_err,
    output logic [REG_W-SHIFT-1:0] m0_base_o,
    output logic [REG_W-SHIFT-1:0] m1_base_o,
    output logic [REG_W-SHIFT-1:0] m0_mask_o,
    output logic [REG_W-SHIFT-1:0] m1_mask_o,
    output logic [REG_W-SHIFT-1:0] rw_base_o,
    output logic [NWIN-1:0]        en_o
);

    localparam int IDX_W = ADDR_W - 3;

    logic [REG_W-1:0] m0_base_q, m1_base_q, m0_mask_q, m1_mask_q, rw_base_q, en_q;
    logic [REG_W-1:0] read_val;
    logic [IDX_W-1:0] idx;
    logic             aligned, known, mem_reg, rw_reg, mem_live;
    logic             bad_wr, do_store;

    assign idx     = cfg_addr[ADDR_W-1:3];
    assign aligned = (cfg_addr[2:0] == 3'd0);

    always_comb begin
        known    = (idx < IDX_W'(NUM_REGS));
        mem_reg  = (idx == IDX_W'(IDX_MEM0_BASE)) || (idx == IDX_W'(IDX_MEM1_BASE)) ||
                   (idx == IDX_W'(IDX_MEM0_MASK)) || (idx == IDX_W'(IDX_MEM1_MASK));
        rw_reg   = (idx == IDX_W'(IDX_REGW_BASE));
        mem_live = en_q[EN_MEM0_BIT] | en_q[EN_MEM1_BIT];
        bad_wr   = cfg_wr && (!aligned || !known || (mem_reg && mem_live) ||
                              (rw_reg && en_q[EN_REGW_BIT]));
        do_store = cfg_wr && aligned && known;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m0_base_q <= DEF_M0_BASE & MEM_KEEP;
            m1_base_q <= DEF_M1_BASE & MEM_KEEP;
            m0_mask_q <= DEF_M0_MASK & MEM_KEEP;
            m1_mask_q <= DEF_M1_MASK & MEM_KEEP;
            rw_base_q <= DEF_RW_BASE & REGW_KEEP;
            en_q      <= '0;
        end else if (do_store) begin
            case (idx)
                IDX_W'(IDX_MEM0_BASE): m0_base_q <= cfg_wdata & MEM_KEEP;
                IDX_W'(IDX_MEM1_BASE): m1_base_q <= cfg_wdata & MEM_KEEP;
                IDX_W'(IDX_MEM0_MASK): m0_mask_q <= cfg_wdata & MEM_KEEP;
                IDX_W'(IDX_MEM1_MASK): m1_mask_q <= cfg_wdata & MEM_KEEP;
                IDX_W'(IDX_REGW_BASE): rw_base_q <= cfg_wdata & REGW_KEEP;
                IDX_W'(IDX_WIN_EN):    en_q      <= cfg_wdata & EN_KEEP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_err <= 1'b0;
        else if (bad_wr)  cfg_err <= 1'b1;
        else if (err_clr) cfg_err <= 1'b0;
    end

    always_comb begin
        case (idx)
            IDX_W'(IDX_MEM0_BASE): read_val = m0_base_q;
            IDX_W'(IDX_MEM1_BASE): read_val = m1_base_q;
            IDX_W'(IDX_MEM0_MASK): read_val = m0_mask_q;
            IDX_W'(IDX_MEM1_MASK): read_val = m1_mask_q;
            IDX_W'(IDX_REGW_BASE): read_val = rw_base_q;
            IDX_W'(IDX_WIN_EN):    read_val = en_q;
            default:               read_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= read_val;
    end

    assign m0_base_o = m0_base_q[REG_W-1:SHIFT];
    assign m1_base_o = m1_base_q[REG_W-1:SHIFT];
    assign m0_mask_o = m0_mask_q[REG_W-1:SHIFT];
    assign m1_mask_o = m1_mask_q[REG_W-1:SHIFT];
    assign rw_base_o = rw_base_q[REG_W-1:SHIFT];
    assign en_o[WIN_MEM0] = en_q[EN_MEM0_BIT];
    assign en_o[WIN_MEM1] = en_q[EN_MEM1_BIT];
    assign en_o[WIN_REGW] = en_q[EN_REGW_BIT];

    // R12: an unknown index or a misaligned address sets the flag on the next edge
    a_r12_bad_index_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (!known || !aligned)) |=> cfg_err);

    // R11: rewriting the register-window base while it is live is flagged
    a_r11_live_regw_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && aligned && rw_reg && en_q[EN_REGW_BIT]) |=> cfg_err);

    // R13: the flag holds until it is cleared
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !err_clr) |=> cfg_err);

    // R13: a clear with no write in the same cycle drops the flag
    a_r13_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !cfg_wr) |=> !cfg_err);

endmodule

// File: rtl/bar_window_match.sv
module bar_window_match #(
    parameter int PA_W = 50,
    parameter int SZ_W = PA_W + 1
) (
    input  logic            en,
    input  logic [PA_W-1:0] base,
    input  logic [SZ_W-1:0] size,
    input  logic [PA_W-1:0] addr,
    output logic            hit,
    output logic [PA_W-1:0] offset
);

    logic [SZ_W-1:0] diff;

    always_comb begin
        diff   = {1'b0, addr} - {1'b0, base};
        hit    = en && (addr >= base) && (diff < size);
        offset = diff[PA_W-1:0];
    end

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select #(
    parameter int NWIN = 3,
    parameter int PA_W = 50
) (
    input  logic [NWIN-1:0]           hit,
    input  logic [NWIN-1:0][PA_W-1:0] offs,
    output logic [NWIN-1:0]           sel,
    output logic [PA_W-1:0]           offset
);

    always_comb begin
        sel    = '0;
        offset = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                offset = offs[i];
            end
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SHIFT     = 14,
    parameter int REGW_SIZE = 4096,
    parameter int PA_W      = REG_W - SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              err_clr,
    output logic              cfg_err,
    input  logic [PA_W-1:0]   lk_addr,
    output logic [NWIN-1:0]   win_hit,
    output logic [NWIN-1:0]   win_sel,
    output logic [PA_W-1:0]   win_offset
);

    localparam int SZ_W = PA_W + 1;

    logic [PA_W-1:0]           m0_base, m1_base, m0_mask, m1_mask, rw_base;
    logic [NWIN-1:0]           en;
    logic [NWIN-1:0][PA_W-1:0] base_arr;
    logic [NWIN-1:0][SZ_W-1:0] size_arr;
    logic [NWIN-1:0][PA_W-1:0] off_arr;

    bar_cfg_regs #(
        .ADDR_W (ADDR_W),
        .SHIFT  (SHIFT)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .err_clr   (err_clr),
        .cfg_err   (cfg_err),
        .m0_base_o (m0_base),
        .m1_base_o (m1_base),
        .m0_mask_o (m0_mask),
        .m1_mask_o (m1_mask),
        .rw_base_o (rw_base),
        .en_o      (en)
    );

    always_comb begin
        base_arr[WIN_MEM0] = m0_base;
        base_arr[WIN_MEM1] = m1_base;
        base_arr[WIN_REGW] = rw_base;
        size_arr[WIN_MEM0] = {1'b0, ~m0_mask} + SZ_W'(1);
        size_arr[WIN_MEM1] = {1'b0, ~m1_mask} + SZ_W'(1);
        size_arr[WIN_REGW] = SZ_W'(REGW_SIZE);
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        bar_window_match #(
            .PA_W (PA_W),
            .SZ_W (SZ_W)
        ) match_i (
            .en     (en[w]),
            .base   (base_arr[w]),
            .size   (size_arr[w]),
            .addr   (lk_addr),
            .hit    (win_hit[w]),
            .offset (off_arr[w])
        );
    end

    bar_hit_select #(
        .NWIN (NWIN),
        .PA_W (PA_W)
    ) sel_i (
        .hit    (win_hit),
        .offs   (off_arr),
        .sel    (win_sel),
        .offset (win_offset)
    );

    // R10: at most one window is selected
    a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));

    // R10: a selected window must be one that hits
    a_r10_sel_within_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel & ~win_hit) == '0);

    // R10: memory window 0 wins whenever it hits
    a_r10_mem0_first: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit[WIN_MEM0] |-> win_sel[WIN_MEM0]);

    // R8: no hit on a disabled window
    a_r8_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit & ~en) == '0);

    // R9: offset is zero when nothing is selected
    a_r9_idle_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == '0) |-> (win_offset == '0));

    // R9: the selected offset reconstructs the looked-up address
    a_r9_offset_rebuilds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel[WIN_MEM1] |-> (win_offset + m1_base == lk_addr));

endmodule

// File: tb/bar_window_decoder_tb_top.sv
`timescale 1ns/1ps
module bar_window_decoder_tb_top;

    typedef struct {
        int          kind;
        logic [63:0] exp_data;
        logic [2:0]  exp_hit;
        logic [2:0]  exp_sel;
        logic [49:0] exp_off;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        err_clr = 1'b0;
    logic        cfg_err;
    logic [49:0] lk_addr = '0;
    logic [2:0]  win_hit;
    logic [2:0]  win_sel;
    logic [49:0] win_offset;

    int    n_checks = 0;
    int    n_fails  = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    bar_window_decoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .err_clr    (err_clr),
        .cfg_err    (cfg_err),
        .lk_addr    (lk_addr),
        .win_hit    (win_hit),
        .win_sel    (win_sel),
        .win_offset (win_offset)
    );

    function automatic logic [5:0] ra(input int i);
        return 6'(i * 8);
    endfunction

    // monitor: compare every queued expectation just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if (it.kind == 0) begin
                    if (cfg_rdata !== it.exp_data) begin
                        n_fails++;
                        $display("FAIL %s rdata actual=%h expected=%h", it.tag, cfg_rdata, it.exp_data);
                    end
                end else if (it.kind == 1) begin
                    if (win_hit !== it.exp_hit || win_sel !== it.exp_sel || win_offset !== it.exp_off) begin
                        n_fails++;
                        $display("FAIL %s hit/sel/off actual=%b/%b/%h expected=%b/%b/%h", it.tag,
                                 win_hit, win_sel, win_offset, it.exp_hit, it.exp_sel, it.exp_off);
                    end
                end else begin
                    if (cfg_err !== it.exp_data[0]) begin
                        n_fails++;
                        $display("FAIL %s err actual=%b expected=%b", it.tag, cfg_err, it.exp_data[0]);
                    end
                end
            end
        end
    end

    task automatic do_wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [63:0] e, input string tag);
        item_t it;
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        it = '{kind: 0, exp_data: e, exp_hit: '0, exp_sel: '0, exp_off: '0, tag: tag};
        sb.push_back(it);
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic chk_lk(input logic [49:0] a, input logic [2:0] h, input logic [2:0] s,
                          input logic [49:0] o, input string tag);
        item_t it;
        @(negedge clk);
        lk_addr = a;
        it = '{kind: 1, exp_data: '0, exp_hit: h, exp_sel: s, exp_off: o, tag: tag};
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_err(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it = '{kind: 2, exp_data: {63'd0, e}, exp_hit: '0, exp_sel: '0, exp_off: '0, tag: tag};
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 / R1: reset values, read latency, unknown index reads zero
        chk_rd(ra(0), 64'h0000_4000_0000_0000, "R5 mem0 base default");
        chk_rd(ra(1), 64'h0000_8000_0000_0000, "R5 mem1 base default");
        chk_rd(ra(2), 64'hFFFF_FC00_0000_0000, "R5 mem0 mask default");
        chk_rd(ra(3), 64'hFFFF_FFC0_0000_0000, "R5 mem1 mask default");
        chk_rd(ra(4), 64'h0000_C000_0000_0000, "R5 regw base default");
        chk_rd(ra(5), 64'h0,                   "R5 enable default");
        chk_rd(ra(7), 64'h0,                   "R1 unknown index reads zero");
        chk_err(1'b0, "R5 err clear after reset");

        // R2 / R3: write masking, windows disabled so no error
        do_wr(ra(0), 64'hFFFF_FFFF_FFFF_FFFF);
        chk_rd(ra(0), 64'hFFFF_FFFF_C000_0000, "R2 mem base keeps 63..30");
        do_wr(ra(3), 64'h0123_4567_89AB_CDEF);
        chk_rd(ra(3), 64'h0123_4567_8000_0000, "R2 mem mask keeps 63..30");
        do_wr(ra(4), 64'hFFFF_FFFF_FFFF_FFFF);
        chk_rd(ra(4), 64'hFFFF_FFFF_FC00_0000, "R3 regw base keeps 63..26");
        chk_err(1'b0, "R11 writes with windows disabled raise nothing");
        do_wr(ra(0), 64'h0000_4000_0000_0000);
        do_wr(ra(3), 64'hFFFF_FFC0_0000_0000);
        do_wr(ra(4), 64'h0000_C000_0000_0000);

        // R8: nothing hits while disabled
        chk_lk(50'h1_0000_0000, 3'b000, 3'b000, 50'h0, "R8 disabled window no hit");

        // R4: enable masking; all windows on
        do_wr(ra(5), 64'hFFFF_FFFF_FFFF_FFFF);
        chk_rd(ra(5), 64'hF800_0000_0000_0000, "R4 enable keeps 63..59");
        chk_err(1'b0, "R11 enable write never flags");

        // R6 / R7: boundaries of the disjoint default windows
        chk_lk(50'h1_0000_0000, 3'b001, 3'b001, 50'h0,         "R6 mem0 first byte");
        chk_lk(50'h1_0FFF_FFFF, 3'b001, 3'b001, 50'h0FFF_FFFF, "R6 mem0 last byte");
        chk_lk(50'h1_1000_0000, 3'b000, 3'b000, 50'h0,         "R6 mem0 one past end");
        chk_lk(50'h0_FFFF_FFFF, 3'b000, 3'b000, 50'h0,         "R6 mem0 one below base");
        chk_lk(50'h2_0000_0123, 3'b010, 3'b010, 50'h123,       "R9 mem1 offset");
        chk_lk(50'h2_00FF_FFFF, 3'b010, 3'b010, 50'hFF_FFFF,   "R6 mem1 last byte");
        chk_lk(50'h2_0100_0000, 3'b000, 3'b000, 50'h0,         "R6 mem1 one past end");
        chk_lk(50'h3_0000_0FFF, 3'b100, 3'b100, 50'hFFF,       "R7 regw last byte");
        chk_lk(50'h3_0000_1000, 3'b000, 3'b000, 50'h0,         "R7 regw one past end");

        // R10: overlap all three windows, peel enables off
        do_wr(ra(5), 64'h0);
        do_wr(ra(1), 64'h0000_4000_0000_0000);
        do_wr(ra(4), 64'h0000_4000_0000_0000);
        chk_err(1'b0, "R11 rebase while disabled no flag");
        do_wr(ra(5), 64'hE000_0000_0000_0000);
        chk_lk(50'h1_0000_0010, 3'b111, 3'b001, 50'h10, "R10 mem0 beats all");
        do_wr(ra(5), 64'h6000_0000_0000_0000);
        chk_lk(50'h1_0000_0010, 3'b110, 3'b010, 50'h10, "R10 mem1 beats regw");
        do_wr(ra(5), 64'h2000_0000_0000_0000);
        chk_lk(50'h1_0000_0010, 3'b100, 3'b100, 50'h10, "R10 regw alone");

        // R11: only the regw window is live; mem base write is silent
        do_wr(ra(0), 64'h0010_0000_0000_0000);
        chk_err(1'b0, "R11 mem write with mem windows off no flag");
        do_wr(ra(4), 64'h0000_C000_0000_0000);
        chk_err(1'b1, "R11 live regw rebase flags");
        chk_rd(ra(4), 64'h0000_C000_0000_0000, "R11 live regw rebase still stored");
        chk_err(1'b1, "R13 flag stays without clear");
        pulse_clr();
        chk_err(1'b0, "R13 clear drops flag");
        do_wr(ra(5), 64'h4000_0000_0000_0000);
        do_wr(ra(2), 64'hFFFF_FF00_0000_0000);
        chk_err(1'b1, "R11 mask write while mem1 live flags");
        chk_rd(ra(2), 64'hFFFF_FF00_0000_0000, "R11 mask write still stored");
        pulse_clr();

        // R6: new base and mask give a new size
        do_wr(ra(5), 64'h8000_0000_0000_0000);
        chk_lk(50'h40_03FF_FFFF, 3'b001, 3'b001, 50'h3FF_FFFF, "R6 rebased mem0 last byte");
        chk_lk(50'h40_0400_0000, 3'b000, 3'b000, 50'h0,        "R6 rebased mem0 past end");
        do_wr(ra(5), 64'h0);

        // R12: unknown index and misaligned address
        do_wr(ra(6), 64'hDEAD_BEEF_0000_0000);
        chk_err(1'b1, "R12 unknown index flags");
        chk_rd(ra(6), 64'h0, "R12 unknown index not stored");
        pulse_clr();
        chk_err(1'b0, "R13 cleared after unknown write");
        do_wr(6'h0B, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_err(1'b1, "R12 misaligned write flags");
        chk_rd(ra(1), 64'h0000_4000_0000_0000, "R12 misaligned write not stored");

        // R13: error and clear in the same cycle, error wins
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = ra(7); cfg_wdata = '0; err_clr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; err_clr = 1'b0;
        chk_err(1'b1, "R13 new error beats clear");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule